// File: doc/BRIEF.md
# Fixed-Point Rounding Right Shifter

This unit shifts one element right by a variable amount and rounds the result instead of dropping the bits that fall off. An element is 8, 16, 32 or 64 bits wide and arrives right-aligned in a 64-bit input. The unit treats it either as unsigned (logical shift) or as two's complement (arithmetic shift). The result has the same width as the element and is zero above it.

Four rounding modes are supported: round-to-nearest-up, round-to-nearest-even, truncate, and round-to-odd. Three bits decide the increment:
- the guard bit, which is the bit just below the cut;
- the sticky bit, which is the OR of every bit below the guard;
- the least significant bit of the truncated result.

A parameter adds an output register. With the register, the result appears one clock after its operands.

Top module: `fxr_round_shift`

## Requirements
- R1: With `OUT_REG`=1 (default), `result_o` is 0 while `rst_ni` is low and otherwise shows the result for the operands sampled at the previous rising clock edge.
- R2: Width code `ewidth_i` selects 0=8, 1=16, 2=32, 3=64 bits. Every bit of `result_o` above the selected width is 0.
- R3: When `shamt_i` is 0, the result equals the element's low width bits unchanged, in every mode and for both shift kinds.
- R4: When `arith_i`=0, bits of `data_i` above the element width are ignored. The element is zero-extended and shifted right logically by `shamt_i` (0 to 63).
- R5: When `arith_i`=1, the element is sign-extended from its width and shifted arithmetically. The rounding LSB comes from that shifted value. Guard and sticky come only from the element's own width bits, so they are 0 beyond the width.
- R6: Mode code 0 (nearest-up) adds the guard bit, which is bit `shamt_i`-1 of the element.
- R7: Mode code 1 (nearest-even) adds guard AND (sticky OR truncated LSB). Sticky is the OR of bits `shamt_i`-2 down to 0 and is 0 when `shamt_i` is below 2.
- R8: Mode code 2 (truncate) adds nothing, so the result is the plain shifted value.
- R9: Mode code 3 (round-to-odd) adds 1 only when the truncated LSB is 0 and guard OR sticky is 1. The result LSB is therefore 1 whenever any shifted-out bit was set.
- R10: The truncated value plus the increment wraps within the element width. For example, 8-bit 0xFF shifted arithmetically by 1 with mode 0 gives 0x00.
- R11: When no bit below the cut is set, every mode returns the plain truncated value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 64 | Element value, right-aligned |
| shamt_i | input | 6 | Right shift amount, 0 to 63 |
| rmode_i | input | 2 | Rounding mode code (0 up, 1 even, 2 truncate, 3 odd) |
| arith_i | input | 1 | 1 = arithmetic shift, 0 = logical shift |
| ewidth_i | input | 2 | Element width code (0=8, 1=16, 2=32, 3=64) |
| result_o | output | 64 | Rounded shifted element, zero above the width |

## Verification
The checker assumes that all operands are known (not X) at every rising edge after reset is released. It also assumes that each registered result belongs to the operands present one edge earlier. The stimulus changes operands only on falling edges and holds them at zero during reset. The stimulus covers all width codes and all shift amounts 0 to 63, including shifts at and beyond the element width. Random data in `data_i` above the element width checks that those bits never leak into the result.

// File: rtl/fxr_pkg.sv
package fxr_pkg;
  localparam int unsigned DW = 64;

  typedef enum logic [1:0] {
    RM_NEAR_UP   = 2'd0,
    RM_NEAR_EVEN = 2'd1,
    RM_DOWN      = 2'd2,
    RM_ODD       = 2'd3
  } rmode_e;

  typedef enum logic [1:0] {
    EW_8  = 2'd0,
    EW_16 = 2'd1,
    EW_32 = 2'd2,
    EW_64 = 2'd3
  } ewidth_e;

  function automatic logic [DW-1:0] ew_mask(input logic [1:0] ew);
    case (ew)
      EW_8:    ew_mask = 64'h0000_0000_0000_00FF;
      EW_16:   ew_mask = 64'h0000_0000_0000_FFFF;
      EW_32:   ew_mask = 64'h0000_0000_FFFF_FFFF;
      default: ew_mask = '1;
    endcase
  endfunction
endpackage

// File: rtl/fxr_operand.sv
// Narrows the element to its width and forms the extended operand.
module fxr_operand #(
  parameter int unsigned DW     = 64,
  parameter int unsigned NUM_EW = 4
) (
  input  logic [DW-1:0] data_i,
  input  logic [1:0]    ewidth_i,
  input  logic          arith_i,
  output logic [DW-1:0] narrow_o,
  output logic [DW-1:0] ext_o
);
  logic [DW-1:0] narrow_w [NUM_EW];
  logic [DW-1:0] ext_w    [NUM_EW];

  for (genvar g = 0; g < NUM_EW; g++) begin : g_ew
    localparam int unsigned W = 8 << g;
    if (W >= DW) begin : g_full
      assign narrow_w[g] = data_i;
      assign ext_w[g]    = data_i;
    end else begin : g_part
      assign narrow_w[g] = {{(DW-W){1'b0}}, data_i[W-1:0]};
      assign ext_w[g]    = {{(DW-W){arith_i & data_i[W-1]}}, data_i[W-1:0]};
    end
  end

  assign narrow_o = narrow_w[ewidth_i];
  assign ext_o    = ext_w[ewidth_i];
endmodule

// File: rtl/fxr_round_inc.sv
// Rounding increment from guard, sticky and truncated LSB.
module fxr_round_inc #(
  parameter int unsigned DW = 64,
  parameter int unsigned SW = $clog2(DW)
) (
  input  logic [DW-1:0] narrow_i,
  input  logic [SW-1:0] shamt_i,
  input  logic [1:0]    rmode_i,
  input  logic          trunc_lsb_i,
  output logic          inc_o
);
  import fxr_pkg::*;

  logic [DW-1:0] guard_sel;
  logic [DW-1:0] below_guard;
  logic          guard;
  logic          sticky;
  logic          nz_shift;

  assign nz_shift    = |shamt_i;
  assign guard_sel   = {{(DW-1){1'b0}}, 1'b1} << (shamt_i - SW'(1));
  assign below_guard = guard_sel - {{(DW-1){1'b0}}, 1'b1};
  assign guard       = nz_shift & |(narrow_i & guard_sel);
  assign sticky      = (shamt_i >= SW'(2)) & |(narrow_i & below_guard);

  always_comb begin
    unique case (rmode_e'(rmode_i))
      RM_NEAR_UP:   inc_o = guard;
      RM_NEAR_EVEN: inc_o = guard & (sticky | trunc_lsb_i);
      RM_DOWN:      inc_o = 1'b0;
      RM_ODD:       inc_o = nz_shift & ~trunc_lsb_i & (guard | sticky);
      default:      inc_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fxr_round_shift.sv
module fxr_round_shift #(
  parameter int unsigned DW      = 64,
  parameter bit          OUT_REG = 1'b1,
  localparam int unsigned SW     = $clog2(DW),
  localparam int unsigned NUM_EW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] data_i,
  input  logic [SW-1:0] shamt_i,
  input  logic [1:0]    rmode_i,
  input  logic          arith_i,
  input  logic [1:0]    ewidth_i,
  output logic [DW-1:0] result_o
);
  import fxr_pkg::*;

  logic [DW-1:0] narrow;
  logic [DW-1:0] ext;
  logic [DW-1:0] trunc;
  logic          inc;
  logic [DW-1:0] res_d;

  fxr_operand #(.DW(DW), .NUM_EW(NUM_EW)) u_operand (
    .data_i   (data_i),
    .ewidth_i (ewidth_i),
    .arith_i  (arith_i),
    .narrow_o (narrow),
    .ext_o    (ext)
  );

  assign trunc = arith_i ? DW'($signed(ext) >>> shamt_i) : (narrow >> shamt_i);

  fxr_round_inc #(.DW(DW), .SW(SW)) u_inc (
    .narrow_i    (narrow),
    .shamt_i     (shamt_i),
    .rmode_i     (rmode_i),
    .trunc_lsb_i (trunc[0]),
    .inc_o       (inc)
  );

  assign res_d = (trunc + {{(DW-1){1'b0}}, inc}) & ew_mask(ewidth_i);

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) result_o <= '0;
      else         result_o <= res_d;
    end
  end else begin : g_comb
    assign result_o = res_d;
  end
endmodule

// File: rtl/fxr_round_shift_chk.sv
module fxr_round_shift_chk #(
  parameter int unsigned DW      = 64,
  parameter int unsigned SW      = 6,
  parameter bit          OUT_REG = 1'b1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] data_i,
  input logic [SW-1:0] shamt_i,
  input logic [1:0]    rmode_i,
  input logic          arith_i,
  input logic [1:0]    ewidth_i,
  input logic [DW-1:0] result_o
);
  import fxr_pkg::*;

  logic [DW-1:0] d_q;
  logic [SW-1:0] sh_q;
  logic [1:0]    rm_q;
  logic          ar_q;
  logic [1:0]    ew_q;
  logic          live;

  if (OUT_REG) begin : g_dly
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        d_q <= '0; sh_q <= '0; rm_q <= '0; ar_q <= 1'b0; ew_q <= '0; live <= 1'b0;
      end else begin
        d_q <= data_i; sh_q <= shamt_i; rm_q <= rmode_i; ar_q <= arith_i;
        ew_q <= ewidth_i; live <= 1'b1;
      end
    end
  end else begin : g_nodly
    assign d_q  = data_i;
    assign sh_q = shamt_i;
    assign rm_q = rmode_i;
    assign ar_q = arith_i;
    assign ew_q = ewidth_i;
    assign live = rst_ni;
  end

  logic [DW-1:0] op;
  logic          lost;
  assign op   = d_q & ew_mask(ew_q);
  assign lost = |(op & ((64'h1 << sh_q) - 64'h1));

  AST_WIDTH_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live |-> ((result_o & ~ew_mask(ew_q)) == '0)); // R2

  AST_ZERO_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && sh_q == '0) |-> (result_o == op)); // R3

  AST_TRUNC_LOGICAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && rm_q == 2'd2 && !ar_q) |-> (result_o == (op >> sh_q))); // R8

  AST_ODD_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && rm_q == 2'd3 && lost) |-> result_o[0]); // R9

  AST_EXACT_LOGICAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && !ar_q && !lost) |-> (result_o == (op >> sh_q))); // R11

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    (OUT_REG && !rst_ni) |-> (result_o == '0)); // R1
endmodule

bind fxr_round_shift fxr_round_shift_chk #(.DW(DW), .SW(SW), .OUT_REG(OUT_REG)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .data_i   (data_i),
  .shamt_i  (shamt_i),
  .rmode_i  (rmode_i),
  .arith_i  (arith_i),
  .ewidth_i (ewidth_i),
  .result_o (result_o)
);

// File: tb/fxr_round_shift_test.sv
`timescale 1ns/1ps
module fxr_round_shift_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] data_i = '0;
  logic [5:0]  shamt_i = '0;
  logic [1:0]  rmode_i = '0;
  logic        arith_i = 1'b0;
  logic [1:0]  ewidth_i = '0;
  logic [63:0] result_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  fxr_round_shift uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .shamt_i(shamt_i),
    .rmode_i(rmode_i), .arith_i(arith_i), .ewidth_i(ewidth_i), .result_o(result_o)
  );

  function automatic logic [63:0] expect_of(logic [63:0] d, int sh, int m, bit a, int ew);
    int w = 8 << ew;
    logic [63:0] msk = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'h1 << w) - 64'h1);
    logic [63:0] u = d & msk;
    logic [63:0] x = (a && u[w-1]) ? (u | ~msk) : u;
    logic [63:0] t;
    bit g = 0, s = 0, inc = 0;
    t = a ? 64'($signed(x) >>> sh) : (u >> sh);
    if (sh > 0) g = u[sh-1];
    for (int k = 0; k < sh - 1; k++) s |= u[k];
    case (m)
      0: inc = g;
      1: inc = g & (s | t[0]);
      2: inc = 0;
      default: inc = (sh > 0) & !t[0] & (g | s);
    endcase
    return (t + 64'(inc)) & msk;
  endfunction

  task automatic check(string req, logic [63:0] exp);
    checks++;
    if (result_o !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h (d=%h sh=%0d m=%0d a=%0b ew=%0d)",
               req, result_o, exp, data_i, shamt_i, rmode_i, arith_i, ewidth_i);
    end
  endtask

  task automatic apply(string req, logic [63:0] d, int sh, int m, bit a, int ew);
    @(negedge clk_i);
    data_i = d; shamt_i = 6'(sh); rmode_i = 2'(m); arith_i = a; ewidth_i = 2'(ew);
    @(negedge clk_i);
    check(req, expect_of(d, sh, m, a, ew));
  endtask

  function automatic string tag_of(int sh, int m);
    if (sh == 0) return "R3";
    case (m)
      0: return "R6";
      1: return "R7";
      2: return "R8";
      default: return "R9";
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk_i);
    check("R1", 64'h0);
    rst_ni = 1'b1;
    // directed corners
    apply("R4", 64'hFFFF_FFFF_FFFF_FF05, 0, 0, 0, 0);
    check("R4", 64'h05);
    apply("R7", 64'h06, 2, 1, 0, 0);
    check("R7", 64'h02);
    apply("R7", 64'h02, 2, 1, 0, 0);
    check("R7", 64'h00);
    apply("R6", 64'h02, 2, 0, 0, 0);
    check("R6", 64'h01);
    apply("R10", 64'hFF, 1, 0, 1, 0);
    check("R10", 64'h00);
    apply("R5", 64'h80, 9, 0, 1, 0);
    check("R5", 64'hFF);
    apply("R9", 64'h04, 1, 3, 0, 0);
    check("R9", 64'h02);
    apply("R9", 64'h05, 1, 3, 0, 0);
    check("R9", 64'h03);
    apply("R8", 64'h8000_0000_0000_0000, 63, 2, 1, 3);
    check("R8", 64'hFFFF_FFFF_FFFF_FFFF);
    apply("R11", 64'hF0, 4, 1, 0, 0);
    check("R11", 64'h0F);
    apply("R2", 64'h1_FFFF, 0, 3, 1, 1);
    check("R2", 64'hFFFF);
    apply("R6", 64'h7FFF_FFFF_FFFF_FFFF, 63, 0, 0, 3);
    check("R6", 64'h1);
    // random sweep
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] d = {$urandom, $urandom};
      int sh = $urandom_range(0, 63);
      int m  = $urandom_range(0, 3);
      bit a  = 1'($urandom);
      int ew = $urandom_range(0, 3);
      apply(tag_of(sh, m), d, sh, m, a, ew);
    end
    // reset mid-run clears the register
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1", 64'h0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule